// File: doc/BRIEF.md
# Correctable Error Counter with Freeze

This block keeps a running tally of correctable error events for one cluster, so that management software, which polls only now and then, can follow how fast errors accumulate. Each error-type input has its own bit in a software-written selection mask. The selected inputs are merged into one count enable, so the tally advances by at most one per clock. A 7-bit count field carries a sticky overflow flag above it. Software clears count bits and the flag by writing ones to them.

The block also holds a freeze latch. A severity map chooses which severity inputs may set it. Once set, the latch drives the `freeze` output until a warm reset, or until software writes a one to the latch's clear bit. The count and overflow state survive a warm reset and are cleared only by the cold (power-good) reset. A small register port gives access to everything. Writes are taken at the clock edge and reads are combinational.

Register addresses: 0 holds the count register, with {overflow, count[6:0]} in bits [7:0]. Address 1 is the selection mask, bit i enabling error input i. Address 2 is the severity map, bit j enabling severity input j, in bits [3:0]. Address 3 holds the freeze status in bit 0, and a write of 1 to that bit clears the latch.

Top module: `errcnt_top`

## Requirements
- R1: After a cold reset, all four registers read 0 and `freeze` is 0.
- R2: When any error input whose selection bit is set is high at a clock edge, the count register reads one higher after that edge. Inputs whose selection bit is clear have no effect on the count.
- R3: The count rises by exactly one in a cycle, however many selected inputs are high together.
- R4: An increment from count 127 yields count 0 with the overflow flag (bit 7 of address 0) set. The flag then stays set through further increments.
- R5: A write to address 0 clears exactly the count and overflow bits written as 1 and leaves the other bits unchanged.
- R6: When a write-1 clear and an increment fall in the same cycle, the clear applies first and the increment is added to the cleared value. A full clear therefore reads 1.
- R7: A warm reset leaves the count and overflow unchanged, but returns the selection mask, the severity map and the freeze latch to 0.
- R8: `freeze` goes high after a clock edge at which a severity input whose map bit is set is high. Severity inputs whose map bit is clear have no effect.
- R9: `freeze` stays high until a warm reset or a write of 1 to bit 0 of address 3. A write of 0 there has no effect. If a mapped severity event and a clear arrive in the same cycle, the latch stays set.
- R10: The selection mask (8 bits) and the severity map (bits [3:0], upper bits reading 0) read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Power-good reset, active low, synchronous; clears everything |
| warmRstN | input | 1 | Warm reset, active low, synchronous; spares count and overflow |
| errIn | input | 8 | Correctable error event per type |
| sevIn | input | 4 | Error event per severity level |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| freeze | output | 1 | Stop-on-error freeze indication |

## Verification
Random error vectors are run against random selection masks. Single-bit and all-bits patterns show whether masking and the one-per-cycle merge are applied, as opposed to a per-input sum. A run of 128 increments separates correct wrapping with a sticky flag from saturation or a lost flag. Partial and full write-1 clears, some issued in the same cycle as an increment, expose a wrong order of clear and add. Mapped and unmapped severity pulses, clears written as 0 and as 1, and a clear colliding with a set event show whether the freeze latch has the right set, hold and release priority. A warm reset in mid-run tells which state is sticky.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;
  localparam int CNT_W = 7;
  localparam int REG_W = CNT_W + 1;

  typedef enum logic [1:0] {
    A_COUNT  = 2'd0,
    A_SELECT = 2'd1,
    A_SEVMAP = 2'd2,
    A_FREEZE = 2'd3
  } reg_addr_e;

  // strobes from control to counter datapath
  typedef struct packed {
    logic             incr;
    logic [REG_W-1:0] clrMask;
  } cnt_strb_t;
endpackage

// File: rtl/errcnt_ctrl.sv
module errcnt_ctrl
  import errcnt_pkg::*;
#(
  parameter int NUM_TYPES = 8,
  parameter int NUM_SEV   = 4
) (
  input  logic                 clk,
  input  logic                 coldRstN,
  input  logic                 warmRstN,
  input  logic [NUM_TYPES-1:0] errIn,
  input  logic [NUM_SEV-1:0]   sevIn,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [REG_W-1:0]     cntVal,
  output logic [REG_W-1:0]     regRdData,
  output logic                 freeze,
  output cnt_strb_t            strb
);
  logic                 rstAny;
  logic                 wrCount, wrSelect, wrSevMap, wrFreeze;
  logic [NUM_TYPES-1:0] selMask;
  logic [NUM_SEV-1:0]   sevMap;
  logic                 frzQ;
  logic                 sevHit;
  logic                 frzClr;

  assign rstAny   = !coldRstN || !warmRstN;
  assign wrCount  = regWrEn && (regAddr == A_COUNT);
  assign wrSelect = regWrEn && (regAddr == A_SELECT);
  assign wrSevMap = regWrEn && (regAddr == A_SEVMAP);
  assign wrFreeze = regWrEn && (regAddr == A_FREEZE);
  assign sevHit   = |(sevIn & sevMap);
  assign frzClr   = wrFreeze && regWrData[0];

  always_comb begin
    strb.incr    = |(errIn & selMask);
    strb.clrMask = wrCount ? regWrData : '0;
  end

  always_ff @(posedge clk) begin
    if (rstAny) begin
      selMask <= '0;
      sevMap  <= '0;
    end else begin
      if (wrSelect) selMask <= regWrData[NUM_TYPES-1:0];
      if (wrSevMap) sevMap  <= regWrData[NUM_SEV-1:0];
    end
  end

  // set has priority over a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (rstAny)      frzQ <= 1'b0;
    else if (sevHit) frzQ <= 1'b1;
    else if (frzClr) frzQ <= 1'b0;
  end

  assign freeze = frzQ;

  always_comb begin
    regRdData = '0;
    case (reg_addr_e'(regAddr))
      A_COUNT:  regRdData = cntVal;
      A_SELECT: regRdData[NUM_TYPES-1:0] = selMask;
      A_SEVMAP: regRdData[NUM_SEV-1:0]   = sevMap;
      A_FREEZE: regRdData[0] = frzQ;
      default:  regRdData = '0;
    endcase
  end

  p_freeze_set_r8: assert property (@(posedge clk) disable iff (rstAny)
    sevHit |=> freeze);
  p_freeze_hold_r9: assert property (@(posedge clk) disable iff (rstAny)
    (freeze && !frzClr) |=> freeze);
  p_freeze_release_r9: assert property (@(posedge clk) disable iff (rstAny)
    (frzClr && !sevHit) |=> !freeze);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rstAny)
    (!freeze && !sevHit) |=> !freeze);
endmodule

// File: rtl/errcnt_dp.sv
module errcnt_dp
  import errcnt_pkg::*;
(
  input  logic             clk,
  input  logic             coldRstN,
  input  cnt_strb_t        strb,
  output logic [REG_W-1:0] cntVal
);
  logic [CNT_W-1:0] cntQ, cleared, sum;
  logic             ovfQ, carry, ovfNext;

  always_comb begin
    cleared        = cntQ & ~strb.clrMask[CNT_W-1:0];
    {carry, sum}   = {1'b0, cleared} + {{CNT_W{1'b0}}, strb.incr};
    ovfNext        = (ovfQ & ~strb.clrMask[CNT_W]) | carry;
  end

  // sticky state: only the cold reset touches it
  always_ff @(posedge clk) begin
    if (!coldRstN) begin
      cntQ <= '0;
      ovfQ <= 1'b0;
    end else begin
      cntQ <= sum;
      ovfQ <= ovfNext;
    end
  end

  assign cntVal = {ovfQ, cntQ};

  p_step_one_r3: assert property (@(posedge clk) disable iff (!coldRstN)
    (strb.incr && strb.clrMask == '0) |=> cntQ == CNT_W'($past(cntQ) + 1'b1));
  p_hold_r5: assert property (@(posedge clk) disable iff (!coldRstN)
    (!strb.incr && strb.clrMask == '0) |=> $stable(cntVal));
  p_wrap_ovf_r4: assert property (@(posedge clk) disable iff (!coldRstN)
    (strb.incr && strb.clrMask == '0 && cntQ == '1) |=> (ovfQ && cntQ == '0));
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!coldRstN)
    (ovfQ && !strb.clrMask[CNT_W]) |=> ovfQ);
  p_clr_then_inc_r6: assert property (@(posedge clk) disable iff (!coldRstN)
    (strb.incr && strb.clrMask[CNT_W-1:0] == '1) |=> cntQ == CNT_W'(1));
endmodule

// File: rtl/errcnt_top.sv
module errcnt_top
  import errcnt_pkg::*;
#(
  parameter int NUM_TYPES = 8,
  parameter int NUM_SEV   = 4
) (
  input  logic                 clk,
  input  logic                 coldRstN,
  input  logic                 warmRstN,
  input  logic [NUM_TYPES-1:0] errIn,
  input  logic [NUM_SEV-1:0]   sevIn,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output logic                 freeze
);
  cnt_strb_t        strb;
  logic [REG_W-1:0] cntVal;

  errcnt_ctrl #(.NUM_TYPES(NUM_TYPES), .NUM_SEV(NUM_SEV)) u_ctrl (
    .clk(clk), .coldRstN(coldRstN), .warmRstN(warmRstN),
    .errIn(errIn), .sevIn(sevIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .cntVal(cntVal), .regRdData(regRdData), .freeze(freeze), .strb(strb)
  );

  errcnt_dp u_dp (
    .clk(clk), .coldRstN(coldRstN), .strb(strb), .cntVal(cntVal)
  );
endmodule

// File: tb/tb_errcnt_top.sv
`timescale 1ns/1ps
module tb_errcnt_top;
  logic       clk = 1'b0;
  logic       coldRstN = 1'b0, warmRstN = 1'b0;
  logic [7:0] errIn = '0;
  logic [3:0] sevIn = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       freeze;

  int checks = 0, errors = 0;

  logic [6:0] mCnt = '0;
  logic       mOvf = 1'b0;
  logic [7:0] mSel = '0;
  logic [3:0] mSev = '0;
  logic       mFrz = 1'b0;

  errcnt_top dut (.*);

  always #4 clk = ~clk;

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [7:0] expRd(input logic [1:0] a);
    case (a)
      2'd0:    return {mOvf, mCnt};
      2'd1:    return mSel;
      2'd2:    return {4'b0, mSev};
      default: return {7'b0, mFrz};
    endcase
  endfunction

  task automatic modelStep(input logic [7:0] e, input logic [3:0] s,
                           input logic w, input logic [1:0] a, input logic [7:0] d);
    logic inc, hit;
    logic [7:0] sum;
    inc = |(e & mSel);
    hit = |(s & mSev);
    if (w && a == 2'd0) begin mCnt = mCnt & ~d[6:0]; mOvf = mOvf & ~d[7]; end
    if (inc) begin
      sum = {1'b0, mCnt} + 8'd1;
      mCnt = sum[6:0];
      mOvf = mOvf | sum[7];
    end
    if (w && a == 2'd1) mSel = d;
    if (w && a == 2'd2) mSev = d[3:0];
    if (hit) mFrz = 1'b1;
    else if (w && a == 2'd3 && d[0]) mFrz = 1'b0;
  endtask

  task automatic cyc(input logic [7:0] e, input logic [3:0] s,
                     input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    errIn = e; sevIn = s; regWrEn = w; regAddr = a; regWrData = d;
    @(posedge clk);
    modelStep(e, s, w, a, d);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(8'h00, 4'h0, 1'b1, a, d);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    @(negedge clk);
    errIn = '0; sevIn = '0; regWrEn = 1'b0; regAddr = a;
    #1;
    checks++;
    if (regRdData !== expRd(a)) begin
      errors++;
      $display("FAIL %s addr %0d got %h exp %h", tag, a, regRdData, expRd(a));
    end
    checks++;
    if (freeze !== mFrz) begin
      errors++;
      $display("FAIL %s freeze got %b exp %b", tag, freeze, mFrz);
    end
  endtask

  task automatic warmReset();
    @(negedge clk);
    errIn = '0; sevIn = '0; regWrEn = 1'b0; warmRstN = 1'b0;
    @(posedge clk);
    mSel = '0; mSev = '0; mFrz = 1'b0;
    @(negedge clk);
    warmRstN = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (2) @(posedge clk);
    @(negedge clk);
    coldRstN = 1'b1; warmRstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) rd(2'(a), "R1");

    // R10 readback
    wr(2'd1, 8'hA5); rd(2'd1, "R10");
    wr(2'd2, 8'hFF); rd(2'd2, "R10");

    // R2 masking
    wr(2'd1, 8'h01);
    cyc(8'h02, 4'h0, 1'b0, 2'd0, 8'h00); rd(2'd0, "R2");
    cyc(8'h01, 4'h0, 1'b0, 2'd0, 8'h00); rd(2'd0, "R2");

    // R3 several selected in one cycle
    wr(2'd1, 8'hFF);
    cyc(8'hFF, 4'h0, 1'b0, 2'd0, 8'h00); rd(2'd0, "R3");
    cyc(8'h81, 4'h0, 1'b0, 2'd0, 8'h00); rd(2'd0, "R3");

    // R5 partial clear
    cyc(8'h10, 4'h0, 1'b0, 2'd0, 8'h00);
    cyc(8'h10, 4'h0, 1'b0, 2'd0, 8'h00);
    wr(2'd0, 8'h01); rd(2'd0, "R5");

    // R4 wrap and sticky overflow
    wr(2'd0, 8'hFF);
    for (int i = 0; i < 127; i++) cyc(8'h04, 4'h0, 1'b0, 2'd0, 8'h00);
    rd(2'd0, "R4");
    cyc(8'h04, 4'h0, 1'b0, 2'd0, 8'h00); rd(2'd0, "R4");
    cyc(8'h04, 4'h0, 1'b0, 2'd0, 8'h00); rd(2'd0, "R4");
    wr(2'd0, 8'h7F); rd(2'd0, "R5");
    wr(2'd0, 8'h80); rd(2'd0, "R5");

    // R6 clear and increment together
    for (int i = 0; i < 3; i++) cyc(8'h20, 4'h0, 1'b0, 2'd0, 8'h00);
    cyc(8'h20, 4'h0, 1'b1, 2'd0, 8'hFF); rd(2'd0, "R6");

    // R8 mapped vs unmapped severity
    wr(2'd2, 8'h02);
    cyc(8'h00, 4'h1, 1'b0, 2'd0, 8'h00); rd(2'd3, "R8");
    cyc(8'h00, 4'h2, 1'b0, 2'd0, 8'h00); rd(2'd3, "R8");

    // R9 hold, clear with 0, clear with 1, set beats clear
    repeat (3) cyc(8'h00, 4'h0, 1'b0, 2'd0, 8'h00);
    rd(2'd3, "R9");
    wr(2'd3, 8'hFE); rd(2'd3, "R9");
    wr(2'd3, 8'h01); rd(2'd3, "R9");
    cyc(8'h00, 4'h2, 1'b1, 2'd3, 8'h01); rd(2'd3, "R9");

    // R7 warm reset keeps count, clears the rest
    for (int i = 0; i < 5; i++) cyc(8'h40, 4'h0, 1'b0, 2'd0, 8'h00);
    warmReset();
    for (int a = 0; a < 4; a++) rd(2'(a), "R7");

    // random mix, R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] e, d;
      logic [3:0] s;
      logic w;
      logic [1:0] a;
      e = 8'($urandom) & 8'($urandom);
      s = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      w = ($urandom_range(0, 9) == 0);
      a = 2'($urandom);
      d = 8'($urandom);
      cyc(e, s, w, a, d);
      if (i % 3 == 0) rd(2'd0, "R2/R3/R4/R5/R6 random");
      if (i % 50 == 7) rd(2'($urandom), "R8/R9/R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule